// File: doc/BRIEF.md
# Serial Port Wire-Mode Controller

This block is the pad-facing control stage of a general-purpose synchronous serial port. A two-bit mode field decides how the port's three pins behave. The pins are a data-out pin, a data-in pin that also serves as the two-wire data line, and a clock pin. In the two modes that do not use two-wire signalling, the pins follow their port and direction bits. The one exception is that three-wire mode puts the shift register's top bit on the data-out pin. In the two two-wire modes, the data and clock pins become open-drain drivers that can only pull the line low.

The block always watches the synchronized pad inputs, whatever the mode. It counts every edge of the clock line in a small counter, and the wrap of that counter raises an overflow flag. A falling data line while the clock line is high raises a start flag. Software clears either flag with a one-cycle strobe. While a flag is pending in a two-wire mode, the block can hold the clock line low, which stretches the bus clock until the software has serviced the event. Each flag has an interrupt request, gated by its own enable and a global enable.

Top module: `swm_ctrl`

## Requirements
- R1: Mode 2'b00: each of the three pins is a plain port pin. Its drive enable equals its direction bit, its driven value equals its port bit, and its pull-up is on when the direction bit is 0 and the port bit is 1.
- R2: Mode 2'b01: the data-out pin drives the shift-register output, with its drive enable still equal to its direction bit. The data-in pin and the clock pin stay plain port pins as in R1.
- R3: Modes 2'b10 and 2'b11: the data line's driven value is 0. Its drive enable is the direction bit AND (shift-register output is 0 OR data port bit is 0). Pull-ups on the data and clock lines are off. The data-out pin stays a plain port pin.
- R4: Modes 2'b10 and 2'b11: the clock line's driven value is 0. Its drive enable is the direction bit AND (clock port bit is 0 OR a hold is active).
- R5: A start condition is a 1-to-0 change of the synchronized data input while the synchronized clock input is 1. In modes 01, 10 and 11 it sets the start flag three clock edges after the pad changes. In mode 00 it sets nothing.
- R6: In modes 10 and 11, a pending start flag is a hold. The clock line stays pulled low (given its direction bit) until the flag is cleared.
- R7: The edge counter counts every change of the synchronized clock input in all four modes. The 16th change after reset sets the overflow flag, and the 15th change does not.
- R8: Only mode 11 treats a pending overflow flag as a hold. In mode 10 the overflow flag does not affect the clock line.
- R9: A 1 on a flag's clear strobe clears that flag at the next edge. When a set and a clear fall on the same edge, the clear wins.
- R10: Each interrupt request equals global enable AND its own enable AND its flag, with no register in the path. Enabling while a flag is pending raises the request in the same cycle.
- R11: After reset both flags are 0 and the edge counter is 0. The synchronizers hold 1, so releasing reset with idle-high lines produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Wire mode select |
| sr_msb_i | input | 1 | Shift-register output bit |
| do_port_i | input | 1 | Port bit of the data-out pin |
| do_dir_i | input | 1 | Direction bit of the data-out pin |
| sda_port_i | input | 1 | Port bit of the data-in / two-wire data pin |
| sda_dir_i | input | 1 | Direction bit of the data-in / two-wire data pin |
| scl_port_i | input | 1 | Port bit of the clock pin |
| scl_dir_i | input | 1 | Direction bit of the clock pin |
| sda_pad_i | input | 1 | Data pad input level |
| scl_pad_i | input | 1 | Clock pad input level |
| start_clr_i | input | 1 | Start-flag clear strobe |
| ovf_clr_i | input | 1 | Overflow-flag clear strobe |
| start_ie_i | input | 1 | Start interrupt enable |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| do_oe_o | output | 1 | Data-out pin drive enable |
| do_out_o | output | 1 | Data-out pin driven value |
| do_pu_o | output | 1 | Data-out pin pull-up enable |
| sda_oe_o | output | 1 | Data pin drive enable |
| sda_out_o | output | 1 | Data pin driven value |
| sda_pu_o | output | 1 | Data pin pull-up enable |
| scl_oe_o | output | 1 | Clock pin drive enable |
| scl_out_o | output | 1 | Clock pin driven value |
| scl_pu_o | output | 1 | Clock pin pull-up enable |
| start_irq_o | output | 1 | Start interrupt request |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions check on every cycle that the pin mapping follows the mode field. They check that a pending start flag keeps the clock driven low in two-wire modes and that mode 10 ignores the overflow flag. They also check that a clear strobe always leaves its flag at 0, that mode 00 never raises the start flag, and that interrupt requests never appear without their enables. Only the bench's scenarios show the timing side. That covers the three-edge latency of start detection, the exact 16th clock change that wraps the counter, and a set and a clear landing on the same edge. It also covers the release of the stretched clock once software clears the flag.

// File: rtl/swm_pkg.sv
// Shared types of the serial wire-mode controller.
package swm_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_3WIRE = 2'b01,
        MODE_2WIRE = 2'b10,
        MODE_2WSTR = 2'b11
    } swm_mode_e;

    localparam int unsigned FLAG_START = 0;
    localparam int unsigned FLAG_OVF   = 1;
    localparam int unsigned NUM_FLAGS  = 2;
endpackage

// File: rtl/swm_sync.sv
// Multi-stage synchronizer for asynchronous pad inputs.
// Assumes: inputs may change at any time; reset value is the idle level.
module swm_sync #(
    parameter int unsigned W       = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the input one stage further toward the core.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage[s] <= RST_VAL;
                else if (s == 0) stage[s] <= d_i;
                else             stage[s] <= stage[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q_o = stage[STAGES-1];
endmodule

// File: rtl/swm_detect.sv
// Start-condition detector and clock-edge counter.
// Assumes: sda_i/scl_i are already synchronized and idle high after reset.
module swm_detect #(
    parameter int unsigned CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_en_i,
    input  logic sda_i,
    input  logic scl_i,
    output logic start_o,
    output logic ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             sda_q, scl_q;
    logic [CNT_W-1:0] cnt;
    logic             scl_edge;

    // Remember the previous synchronized line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_i;
            scl_q <= scl_i;
        end
    end

    assign scl_edge = scl_i ^ scl_q;

    // Count every clock-line change, in every mode.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (scl_edge) cnt <= cnt + CNT_W'(1);
    end

    assign start_o = det_en_i && sda_q && !sda_i && scl_i;
    assign ovf_o   = scl_edge && (cnt == CNT_MAX);
endmodule

// File: rtl/swm_flags.sv
// Sticky event flags with clear-wins priority and gated interrupt requests.
// Assumes: set and clear strobes are single-cycle and synchronous.
module swm_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] ie_i,
    input  logic         gie_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] irq_o
);
    generate
        for (genvar f = 0; f < N; f++) begin : g_flag
            // Hold the flag; a clear overrides a set on the same edge.
            always_ff @(posedge clk) begin
                if (!rst_n)        flag_o[f] <= 1'b0;
                else if (clr_i[f]) flag_o[f] <= 1'b0;
                else if (set_i[f]) flag_o[f] <= 1'b1;
            end
            assign irq_o[f] = gie_i && ie_i[f] && flag_o[f];
        end
    endgenerate
endmodule

// File: rtl/swm_padmux.sv
// Mode-dependent pin driver mapping (purely combinational).
// Assumes: two-wire pins are open drain, so only a low level is ever driven.
module swm_padmux
    import swm_pkg::*;
(
    input  swm_mode_e mode_i,
    input  logic      sr_msb_i,
    input  logic      do_port_i,
    input  logic      do_dir_i,
    input  logic      sda_port_i,
    input  logic      sda_dir_i,
    input  logic      scl_port_i,
    input  logic      scl_dir_i,
    input  logic      hold_i,
    output logic      do_oe_o,
    output logic      do_out_o,
    output logic      do_pu_o,
    output logic      sda_oe_o,
    output logic      sda_out_o,
    output logic      sda_pu_o,
    output logic      scl_oe_o,
    output logic      scl_out_o,
    output logic      scl_pu_o
);
    // Select pin behaviour per mode; plain port behaviour is the default.
    always_comb begin
        do_oe_o   = do_dir_i;
        do_out_o  = do_port_i;
        do_pu_o   = !do_dir_i && do_port_i;
        sda_oe_o  = sda_dir_i;
        sda_out_o = sda_port_i;
        sda_pu_o  = !sda_dir_i && sda_port_i;
        scl_oe_o  = scl_dir_i;
        scl_out_o = scl_port_i;
        scl_pu_o  = !scl_dir_i && scl_port_i;
        unique case (mode_i)
            MODE_3WIRE: do_out_o = sr_msb_i;
            MODE_2WIRE, MODE_2WSTR: begin
                sda_out_o = 1'b0;
                sda_oe_o  = sda_dir_i && (!sr_msb_i || !sda_port_i);
                sda_pu_o  = 1'b0;
                scl_out_o = 1'b0;
                scl_oe_o  = scl_dir_i && (!scl_port_i || hold_i);
                scl_pu_o  = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/swm_ctrl.sv
// Serial wire-mode controller top: synchronizes pads, detects start and
// counter overflow, keeps flags/interrupts and maps pins per mode.
// Assumes: pad inputs asynchronous, all other inputs synchronous to clk.
module swm_ctrl
    import swm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       sr_msb_i,
    input  logic       do_port_i,
    input  logic       do_dir_i,
    input  logic       sda_port_i,
    input  logic       sda_dir_i,
    input  logic       scl_port_i,
    input  logic       scl_dir_i,
    input  logic       sda_pad_i,
    input  logic       scl_pad_i,
    input  logic       start_clr_i,
    input  logic       ovf_clr_i,
    input  logic       start_ie_i,
    input  logic       ovf_ie_i,
    input  logic       gie_i,
    output logic       do_oe_o,
    output logic       do_out_o,
    output logic       do_pu_o,
    output logic       sda_oe_o,
    output logic       sda_out_o,
    output logic       sda_pu_o,
    output logic       scl_oe_o,
    output logic       scl_out_o,
    output logic       scl_pu_o,
    output logic       start_irq_o,
    output logic       ovf_irq_o
);
    swm_mode_e              mode;
    logic [1:0]             pad_s;
    logic                   start_pulse, ovf_pulse;
    logic [NUM_FLAGS-1:0]   set_v, clr_v, ie_v, flag_v, irq_v;
    logic                   start_flag, ovf_flag, hold;

    assign mode = swm_mode_e'(mode_i);

    swm_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({scl_pad_i, sda_pad_i}), .q_o(pad_s)
    );

    swm_detect #(.CNT_W(CNT_W)) u_det (
        .clk(clk), .rst_n(rst_n),
        .det_en_i(mode != MODE_OFF),
        .sda_i(pad_s[0]), .scl_i(pad_s[1]),
        .start_o(start_pulse), .ovf_o(ovf_pulse)
    );

    assign set_v[FLAG_START] = start_pulse;
    assign set_v[FLAG_OVF]   = ovf_pulse;
    assign clr_v[FLAG_START] = start_clr_i;
    assign clr_v[FLAG_OVF]   = ovf_clr_i;
    assign ie_v[FLAG_START]  = start_ie_i;
    assign ie_v[FLAG_OVF]    = ovf_ie_i;

    swm_flags #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_i(set_v), .clr_i(clr_v), .ie_i(ie_v), .gie_i(gie_i),
        .flag_o(flag_v), .irq_o(irq_v)
    );

    assign start_flag  = flag_v[FLAG_START];
    assign ovf_flag    = flag_v[FLAG_OVF];
    assign start_irq_o = irq_v[FLAG_START];
    assign ovf_irq_o   = irq_v[FLAG_OVF];
    assign hold        = start_flag || (mode == MODE_2WSTR && ovf_flag);

    swm_padmux u_pad (
        .mode_i(mode), .sr_msb_i(sr_msb_i),
        .do_port_i(do_port_i), .do_dir_i(do_dir_i),
        .sda_port_i(sda_port_i), .sda_dir_i(sda_dir_i),
        .scl_port_i(scl_port_i), .scl_dir_i(scl_dir_i),
        .hold_i(hold),
        .do_oe_o(do_oe_o), .do_out_o(do_out_o), .do_pu_o(do_pu_o),
        .sda_oe_o(sda_oe_o), .sda_out_o(sda_out_o), .sda_pu_o(sda_pu_o),
        .scl_oe_o(scl_oe_o), .scl_out_o(scl_out_o), .scl_pu_o(scl_pu_o)
    );
endmodule

// File: rtl/swm_ctrl_chk.sv
// Property checker for swm_ctrl, attached through bind.
// Assumes: reset is synchronous active low.
module swm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       sda_port_i,
    input logic       sda_dir_i,
    input logic       scl_port_i,
    input logic       scl_dir_i,
    input logic       start_clr_i,
    input logic       ovf_clr_i,
    input logic       start_ie_i,
    input logic       gie_i,
    input logic       sda_oe_o,
    input logic       sda_out_o,
    input logic       sda_pu_o,
    input logic       scl_oe_o,
    input logic       scl_pu_o,
    input logic       start_irq_o,
    input logic       start_flag,
    input logic       ovf_flag
);
    // R1: mode 00 leaves the data pin as a plain port pin
    a_r1_plain_pin: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b00 |-> (sda_oe_o == sda_dir_i && sda_out_o == sda_port_i));

    // R3: two-wire modes drive only low and disable pull-ups
    a_r3_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[1] |-> (!sda_out_o && !sda_pu_o && !scl_pu_o));

    // R6: pending start flag keeps the clock pulled low
    a_r6_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && scl_dir_i && start_flag) |-> scl_oe_o);

    // R8: mode 10 ignores the overflow flag for holding
    a_r8_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && scl_port_i && !start_flag && ovf_flag) |-> !scl_oe_o);

    // R9: a clear strobe always wins
    a_r9_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr_i |=> !start_flag);
    a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr_i |=> !ovf_flag);

    // R5: mode 00 never raises the start flag
    a_r5_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && !start_flag) |=> !start_flag);

    // R10: no request without its enables
    a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        start_irq_o |-> (gie_i && start_ie_i && start_flag));
endmodule

bind swm_ctrl swm_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .sda_port_i(sda_port_i), .sda_dir_i(sda_dir_i),
    .scl_port_i(scl_port_i), .scl_dir_i(scl_dir_i),
    .start_clr_i(start_clr_i), .ovf_clr_i(ovf_clr_i),
    .start_ie_i(start_ie_i), .gie_i(gie_i),
    .sda_oe_o(sda_oe_o), .sda_out_o(sda_out_o), .sda_pu_o(sda_pu_o),
    .scl_oe_o(scl_oe_o), .scl_pu_o(scl_pu_o),
    .start_irq_o(start_irq_o), .start_flag(start_flag), .ovf_flag(ovf_flag)
);

// File: tb/test_swm_ctrl.sv
// Directed bench for swm_ctrl: one task per scenario, each checking itself.
module test_swm_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic sr_msb_i = 1'b0, do_port_i = 1'b0, do_dir_i = 1'b0;
    logic sda_port_i = 1'b0, sda_dir_i = 1'b0, scl_port_i = 1'b0, scl_dir_i = 1'b0;
    logic sda_pad_i = 1'b1, scl_pad_i = 1'b1;
    logic start_clr_i = 1'b0, ovf_clr_i = 1'b0;
    logic start_ie_i = 1'b0, ovf_ie_i = 1'b0, gie_i = 1'b0;
    logic do_oe_o, do_out_o, do_pu_o, sda_oe_o, sda_out_o, sda_pu_o;
    logic scl_oe_o, scl_out_o, scl_pu_o, start_irq_o, ovf_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    swm_ctrl i_swm_ctrl (.*);

    // Compare one observed value against its expectation.
    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset with idle-high lines and all enables/strobes off.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sda_pad_i = 1'b1; scl_pad_i = 1'b1;
        start_clr_i = 1'b0; ovf_clr_i = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        do_reset();
        mode_i = 2'b10; gie_i = 1; start_ie_i = 1; ovf_ie_i = 1;
        scl_dir_i = 1; scl_port_i = 1;
        tick(4); #1;
        check("R11 irqs after reset", {2'b0, start_irq_o, ovf_irq_o}, 4'b0000);
        check("R11 no hold after reset", {3'b0, scl_oe_o}, 4'b0000);
        gie_i = 0; start_ie_i = 0; ovf_ie_i = 0;
    endtask

    task automatic t_plain();
        do_reset();
        mode_i = 2'b00;
        for (int p = 0; p < 4; p++) begin
            {do_dir_i, do_port_i} = 2'(p);
            {sda_dir_i, sda_port_i} = 2'(p);
            {scl_dir_i, scl_port_i} = 2'(3 - p);
            sr_msb_i = ~p[0];
            #1;
            check("R1 do pin", {1'b0, do_oe_o, do_out_o, do_pu_o},
                  {1'b0, p[1], p[0], ~p[1] & p[0]});
            check("R1 sda pin", {1'b0, sda_oe_o, sda_out_o, sda_pu_o},
                  {1'b0, p[1], p[0], ~p[1] & p[0]});
            check("R1 scl pin", {1'b0, scl_oe_o, scl_out_o, scl_pu_o},
                  {1'b0, ~p[1], ~p[0], p[1] & ~p[0]});
            tick(1);
        end
    endtask

    task automatic t_threewire();
        do_reset();
        mode_i = 2'b01;
        do_dir_i = 1; do_port_i = 0; sr_msb_i = 1;
        sda_dir_i = 0; sda_port_i = 1; scl_dir_i = 1; scl_port_i = 0;
        #1;
        check("R2 do follows shift reg", {2'b0, do_oe_o, do_out_o}, 4'b0011);
        check("R2 sda plain", {1'b0, sda_oe_o, sda_out_o, sda_pu_o}, 4'b0011);
        check("R2 scl plain", {1'b0, scl_oe_o, scl_out_o, scl_pu_o}, 4'b0100);
        do_dir_i = 0; sr_msb_i = 0; #1;
        check("R2 do direction", {2'b0, do_oe_o, do_out_o}, 4'b0000);
    endtask

    task automatic t_twowire_data();
        do_reset();
        mode_i = 2'b10; sda_dir_i = 1; do_dir_i = 1; do_port_i = 1;
        for (int p = 0; p < 4; p++) begin
            {sr_msb_i, sda_port_i} = 2'(p);
            #1;
            check("R3 sda open drain", {1'b0, sda_oe_o, sda_out_o, sda_pu_o},
                  {1'b0, p != 3, 2'b00});
        end
        check("R3 do plain in two-wire", {1'b0, do_oe_o, do_out_o, do_pu_o}, 4'b0110);
        sda_dir_i = 0; sr_msb_i = 0; #1;
        check("R3 sda released without dir", {3'b0, sda_oe_o}, 4'b0000);
        scl_dir_i = 1; scl_port_i = 0; #1;
        check("R4 scl low from port", {1'b0, scl_oe_o, scl_out_o, scl_pu_o}, 4'b0100);
        scl_port_i = 1; #1;
        check("R4 scl released", {1'b0, scl_oe_o, scl_out_o, scl_pu_o}, 4'b0000);
        sda_dir_i = 0; sda_port_i = 1; #1;
        check("R3 pull-up off", {3'b0, sda_pu_o}, 4'b0000);
    endtask

    // Drive a start condition; flag lands three edges later.
    task automatic make_start();
        sda_pad_i = 1'b0;
        tick(4);
        sda_pad_i = 1'b1;
        tick(3);
    endtask

    task automatic t_start();
        do_reset();
        mode_i = 2'b00; gie_i = 1; start_ie_i = 1;
        make_start(); #1;
        check("R5 mode 00 no start", {3'b0, start_irq_o}, 4'b0000);
        mode_i = 2'b01;
        scl_pad_i = 1'b0; tick(4);
        sda_pad_i = 1'b0; tick(5); #1;
        check("R5 no start with clock low", {3'b0, start_irq_o}, 4'b0000);
        sda_pad_i = 1'b1; tick(4);
        scl_pad_i = 1'b1; tick(4);
        sda_pad_i = 1'b0;
        tick(2); #1;
        check("R5 not yet after two edges", {3'b0, start_irq_o}, 4'b0000);
        tick(1); #1;
        check("R5 start at third edge", {3'b0, start_irq_o}, 4'b0001);
        sda_pad_i = 1'b1;
        start_clr_i = 1; tick(1); start_clr_i = 0; #1;
        check("R9 start cleared", {3'b0, start_irq_o}, 4'b0000);
        gie_i = 0; start_ie_i = 0;
    endtask

    task automatic t_hold();
        do_reset();
        mode_i = 2'b11; scl_dir_i = 1; scl_port_i = 1;
        make_start(); #1;
        check("R6 start holds clock", {3'b0, scl_oe_o}, 4'b0001);
        tick(5); #1;
        check("R6 hold persists", {3'b0, scl_oe_o}, 4'b0001);
        start_clr_i = 1; tick(1); start_clr_i = 0; #1;
        check("R6 hold released", {3'b0, scl_oe_o}, 4'b0000);
    endtask

    task automatic t_overflow();
        do_reset();
        mode_i = 2'b00; gie_i = 1; ovf_ie_i = 1;
        for (int e = 0; e < 15; e++) begin
            scl_pad_i = ~scl_pad_i; tick(4);
        end
        #1;
        check("R7 no overflow at 15", {3'b0, ovf_irq_o}, 4'b0000);
        scl_pad_i = ~scl_pad_i; tick(4); #1;
        check("R7 overflow at 16", {3'b0, ovf_irq_o}, 4'b0001);
        scl_pad_i = 1'b1; tick(4);
        mode_i = 2'b10; scl_dir_i = 1; scl_port_i = 1; #1;
        check("R8 mode 10 no stretch", {3'b0, scl_oe_o}, 4'b0000);
        mode_i = 2'b11; #1;
        check("R8 mode 11 stretch", {3'b0, scl_oe_o}, 4'b0001);
        ovf_clr_i = 1; tick(1); ovf_clr_i = 0; #1;
        check("R9 overflow cleared", {2'b0, scl_oe_o, ovf_irq_o}, 4'b0000);
        gie_i = 0; ovf_ie_i = 0;
    endtask

    task automatic t_clear_priority();
        do_reset();
        mode_i = 2'b10; gie_i = 1; start_ie_i = 1; scl_dir_i = 1; scl_port_i = 1;
        sda_pad_i = 1'b0;
        tick(2);
        start_clr_i = 1;
        tick(1);
        start_clr_i = 0; #1;
        check("R9 clear beats set", {2'b0, start_irq_o, scl_oe_o}, 4'b0000);
        tick(2); #1;
        check("R9 stays clear", {3'b0, start_irq_o}, 4'b0000);
        sda_pad_i = 1'b1; tick(4);
        gie_i = 0; start_ie_i = 0;
    endtask

    task automatic t_irq();
        do_reset();
        mode_i = 2'b10;
        make_start();
        gie_i = 1; start_ie_i = 0; #1;
        check("R10 enable off", {3'b0, start_irq_o}, 4'b0000);
        start_ie_i = 1; #1;
        check("R10 immediate request", {3'b0, start_irq_o}, 4'b0001);
        gie_i = 0; #1;
        check("R10 global gate", {3'b0, start_irq_o}, 4'b0000);
        start_ie_i = 0;
    endtask

    initial begin
        t_reset();
        t_plain();
        t_threewire();
        t_twowire_data();
        t_start();
        t_hold();
        t_overflow();
        t_clear_priority();
        t_irq();
        done = 1'b1;
    end

    // Watchdog plus single summary exit.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule